// File: doc/BRIEF.md
# Doorbell-Triggered Command Ring Fetch Controller

This block walks per-channel rings of work descriptors on behalf of a command engine. Each ring slot holds two 32-bit words: a span base address and a span length. Together they point at a run of commands in memory. Software owns a produce cursor per channel and the controller owns a consume cursor. Both cursors live in a small register file inside the block.

Software fills slots and moves its produce cursor. This alone does nothing. Work is found only when software writes a doorbell that carries a channel token. The controller then samples that channel's produce cursor and reads each pending slot in ring order. For every slot with a non-zero length it issues one span fetch request. It waits for that span to be reported consumed before it moves the consume cursor and touches the next slot.

A doorbell that lands while a walk is in progress is remembered. It makes the controller sample the produce cursor again once the current walk ends. When several channels are waiting, the lowest token is served first, and each walk runs to the end before another channel starts.

Top module: `ring_fetch_ctrl`

## Requirements
- R1: After synchronous reset every consume and produce cursor is 0, no doorbell is pending, and `ent_req` and `span_req` are low.
- R2: A slot's first word is the span base and its second word the span length. Each `span_req` carries exactly the base and length of the slot just read, tagged with its channel, in slot order within that channel.
- R3: Writing a produce cursor starts no slot read and no span request. A doorbell write with token t makes the controller sample channel t's produce cursor and walk its pending slots.
- R4: The ring depth is a power of two. A walk reads slots from the consume index up to, but not including, the sampled produce index, and wraps modulo the depth. Equal cursors mean an empty ring, and a doorbell on an empty ring produces no request.
- R5: The consume cursor of a channel moves up by exactly one per slot, and only after that slot is finished. The cursor read port returns a channel's consume cursor one clock after the channel is presented.
- R6: A slot whose length word is 0 produces no span request. Its consume cursor still advances past it.
- R7: At most one span is outstanding. After `span_req`, neither a slot read nor another span request occurs until `span_done` is seen.
- R8: A doorbell for a channel that is already being walked is held pending. Once the walk ends, the produce cursor is sampled again, and slots added before that doorbell are processed with no further doorbell.
- R9: When several channels have pending doorbells, the lowest token is served first, and one channel's walk completes before the next channel's starts.
- R10: The slot address on `ent_addr` is the channel number in the upper bits, joined to the slot index in the lower bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| db_wr | input | 1 | Doorbell write strobe |
| db_token | input | CH_W | Channel token carried by the doorbell |
| put_we | input | 1 | Produce cursor write strobe |
| put_ch | input | CH_W | Channel whose produce cursor is written |
| put_val | input | IDX_W | New produce cursor value |
| cur_rd_ch | input | CH_W | Channel selected on the cursor read port |
| cur_rd_get | output | IDX_W | Consume cursor of the selected channel, one clock later |
| ent_req | output | 1 | One-clock slot read request |
| ent_addr | output | CH_W+IDX_W | Slot address {channel, index} |
| ent_rvalid | input | 1 | Slot read data valid |
| ent_base | input | DW | Slot word 0: span base |
| ent_len | input | DW | Slot word 1: span length |
| span_req | output | 1 | One-clock span fetch request |
| span_ch | output | CH_W | Channel of the requested span |
| span_base | output | DW | Span base address |
| span_len | output | DW | Span length |
| span_done | input | 1 | The outstanding span has been consumed |

## Verification
Suppose the consume cursor is stored wrong, or is advanced at the wrong time. The next walk on that channel then reads the wrong slot, and the span request carries a base and length that differ from the expected slot. This shows at the first `span_req` that follows. The cursor read port also shows the error at the end of each scenario.

A lost pending flag shows as slots that are never requested, and this is caught when the run settles. A wrong arbitration shows as the span order across channels. A missed wait on `span_done` shows on the very next `ent_req` or `span_req` while a span is still open.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  typedef enum logic [2:0] {
    W_IDLE,
    W_LOAD,
    W_WALK,
    W_ENT,
    W_SPAN
  } walk_state_e;
endpackage

// File: rtl/cursor_regs.sv
module cursor_regs #(
  parameter int NCH  = 4,
  parameter int RING = 8,
  localparam int CH_W  = $clog2(NCH),
  localparam int IDX_W = $clog2(RING)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             put_we,
  input  logic [CH_W-1:0]  put_ch,
  input  logic [IDX_W-1:0] put_val,
  input  logic             get_we,
  input  logic [CH_W-1:0]  get_wch,
  input  logic [IDX_W-1:0] get_wval,
  input  logic [CH_W-1:0]  rd_ch,
  output logic [IDX_W-1:0] put_q,
  output logic [IDX_W-1:0] get_q,
  input  logic [CH_W-1:0]  sw_ch,
  output logic [IDX_W-1:0] sw_get_q
);
  // Small per-channel cursor file with registered reads.
  logic [IDX_W-1:0] put_mem [NCH];
  logic [IDX_W-1:0] get_mem [NCH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        put_mem[i] <= '0;
        get_mem[i] <= '0;
      end
      put_q    <= '0;
      get_q    <= '0;
      sw_get_q <= '0;
    end else begin
      if (put_we) put_mem[put_ch] <= put_val;
      if (get_we) get_mem[get_wch] <= get_wval;
      put_q    <= put_mem[rd_ch];
      get_q    <= get_mem[rd_ch];
      sw_get_q <= get_mem[sw_ch];
    end
  end

  // R5: the consume cursor only ever steps by one slot
  a_r5_get_steps_one: assert property (@(posedge clk) disable iff (rst)
    get_we |-> (get_wval == IDX_W'(get_mem[get_wch] + 1'b1)));
endmodule

// File: rtl/doorbell_pend.sv
module doorbell_pend #(
  parameter int NCH = 4,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            db_wr,
  input  logic [CH_W-1:0] db_token,
  input  logic            take,
  output logic            pend_any,
  output logic [CH_W-1:0] pick_ch
);
  logic [NCH-1:0] pend_q;
  logic [NCH-1:0] grant;
  logic [NCH-1:0] set_v;
  logic           found;

  // Lowest-token-first pick.
  always_comb begin
    grant   = '0;
    pick_ch = '0;
    found   = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (pend_q[i] && !found) begin
        grant[i] = 1'b1;
        pick_ch  = CH_W'(i);
        found    = 1'b1;
      end
    end
  end

  assign pend_any = |pend_q;
  assign set_v    = db_wr ? (NCH'(1) << db_token) : '0;

  // A new doorbell wins over the clear of the same channel.
  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~(take ? grant : '0)) | set_v;
  end

  // R8: every doorbell leaves its channel pending
  a_r8_db_marks_pending: assert property (@(posedge clk) disable iff (rst)
    (db_wr && (int'(db_token) < NCH)) |=> pend_q[$past(db_token)]);
  // R9: one channel granted at a time
  a_r9_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
endmodule

// File: rtl/ring_walker.sv
module ring_walker
  import fetch_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int RING = 8,
  parameter int DW   = 32,
  localparam int CH_W  = $clog2(NCH),
  localparam int IDX_W = $clog2(RING)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  pend_any,
  input  logic [CH_W-1:0]       pick_ch,
  output logic                  take,
  output logic [CH_W-1:0]       rd_ch,
  input  logic [IDX_W-1:0]      put_q,
  input  logic [IDX_W-1:0]      get_q,
  output logic                  ent_req,
  output logic [CH_W+IDX_W-1:0] ent_addr,
  input  logic                  ent_rvalid,
  input  logic [DW-1:0]         ent_base,
  input  logic [DW-1:0]         ent_len,
  output logic                  span_req,
  output logic [CH_W-1:0]       span_ch,
  output logic [DW-1:0]         span_base,
  output logic [DW-1:0]         span_len,
  input  logic                  span_done,
  output logic                  get_we,
  output logic [CH_W-1:0]       get_wch,
  output logic [IDX_W-1:0]      get_wval
);
  walk_state_e      state;
  logic [CH_W-1:0]  cur_ch;
  logic [IDX_W-1:0] put_r;
  logic [IDX_W-1:0] get_r;
  logic [IDX_W-1:0] get_nx;

  assign take    = (state == W_IDLE) && pend_any;
  assign rd_ch   = (state == W_IDLE) ? pick_ch : cur_ch;
  assign get_wch = cur_ch;
  assign get_nx  = get_r + 1'b1;   // wraps modulo RING

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= W_IDLE;
      cur_ch    <= '0;
      put_r     <= '0;
      get_r     <= '0;
      ent_req   <= 1'b0;
      ent_addr  <= '0;
      span_req  <= 1'b0;
      span_ch   <= '0;
      span_base <= '0;
      span_len  <= '0;
      get_we    <= 1'b0;
      get_wval  <= '0;
    end else begin
      ent_req  <= 1'b0;
      span_req <= 1'b0;
      get_we   <= 1'b0;
      unique case (state)
        W_IDLE: if (pend_any) begin
          cur_ch <= pick_ch;
          state  <= W_LOAD;
        end
        W_LOAD: begin
          put_r <= put_q;
          get_r <= get_q;
          state <= W_WALK;
        end
        W_WALK: begin
          if (get_r == put_r) begin
            state <= W_IDLE;
          end else begin
            ent_req  <= 1'b1;
            ent_addr <= {cur_ch, get_r};
            state    <= W_ENT;
          end
        end
        W_ENT: if (ent_rvalid) begin
          if (ent_len == '0) begin
            get_r    <= get_nx;
            get_we   <= 1'b1;
            get_wval <= get_nx;
            state    <= W_WALK;
          end else begin
            span_req  <= 1'b1;
            span_ch   <= cur_ch;
            span_base <= ent_base;
            span_len  <= ent_len;
            state     <= W_SPAN;
          end
        end
        W_SPAN: if (span_done) begin
          get_r    <= get_nx;
          get_we   <= 1'b1;
          get_wval <= get_nx;
          state    <= W_WALK;
        end
        default: state <= W_IDLE;
      endcase
    end
  end

  // R6: an empty slot never turns into a span request
  a_r6_zero_len_skipped: assert property (@(posedge clk) disable iff (rst)
    (state == W_ENT && ent_rvalid && ent_len == '0) |=> (!span_req && get_we));
  // R5: the cursor moves only after a slot was finished
  a_r5_get_after_consume: assert property (@(posedge clk) disable iff (rst)
    get_we |-> ($past(span_done) || $past(ent_rvalid)));
  // R7: requests are single-cycle pulses
  a_r7_span_pulse: assert property (@(posedge clk) disable iff (rst)
    span_req |=> !span_req);
endmodule

// File: rtl/ring_fetch_ctrl.sv
module ring_fetch_ctrl #(
  parameter int NCH  = 4,
  parameter int RING = 8,
  parameter int DW   = 32,
  localparam int CH_W  = $clog2(NCH),
  localparam int IDX_W = $clog2(RING)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  db_wr,
  input  logic [CH_W-1:0]       db_token,
  input  logic                  put_we,
  input  logic [CH_W-1:0]       put_ch,
  input  logic [IDX_W-1:0]      put_val,
  input  logic [CH_W-1:0]       cur_rd_ch,
  output logic [IDX_W-1:0]      cur_rd_get,
  output logic                  ent_req,
  output logic [CH_W+IDX_W-1:0] ent_addr,
  input  logic                  ent_rvalid,
  input  logic [DW-1:0]         ent_base,
  input  logic [DW-1:0]         ent_len,
  output logic                  span_req,
  output logic [CH_W-1:0]       span_ch,
  output logic [DW-1:0]         span_base,
  output logic [DW-1:0]         span_len,
  input  logic                  span_done
);
  logic             pend_any;
  logic [CH_W-1:0]  pick_ch;
  logic             take;
  logic [CH_W-1:0]  rd_ch;
  logic [IDX_W-1:0] put_q;
  logic [IDX_W-1:0] get_q;
  logic             get_we;
  logic [CH_W-1:0]  get_wch;
  logic [IDX_W-1:0] get_wval;

  doorbell_pend #(.NCH(NCH)) u_pend (
    .clk(clk), .rst(rst), .db_wr(db_wr), .db_token(db_token),
    .take(take), .pend_any(pend_any), .pick_ch(pick_ch)
  );

  cursor_regs #(.NCH(NCH), .RING(RING)) u_cur (
    .clk(clk), .rst(rst),
    .put_we(put_we), .put_ch(put_ch), .put_val(put_val),
    .get_we(get_we), .get_wch(get_wch), .get_wval(get_wval),
    .rd_ch(rd_ch), .put_q(put_q), .get_q(get_q),
    .sw_ch(cur_rd_ch), .sw_get_q(cur_rd_get)
  );

  ring_walker #(.NCH(NCH), .RING(RING), .DW(DW)) u_walk (
    .clk(clk), .rst(rst),
    .pend_any(pend_any), .pick_ch(pick_ch), .take(take), .rd_ch(rd_ch),
    .put_q(put_q), .get_q(get_q),
    .ent_req(ent_req), .ent_addr(ent_addr), .ent_rvalid(ent_rvalid),
    .ent_base(ent_base), .ent_len(ent_len),
    .span_req(span_req), .span_ch(span_ch), .span_base(span_base),
    .span_len(span_len), .span_done(span_done),
    .get_we(get_we), .get_wch(get_wch), .get_wval(get_wval)
  );

  // Edge bookkeeping used only by the assertions below.
  logic span_open;
  logic db_seen;
  always_ff @(posedge clk) begin
    if (rst) begin
      span_open <= 1'b0;
      db_seen   <= 1'b0;
    end else begin
      if (span_req)       span_open <= 1'b1;
      else if (span_done) span_open <= 1'b0;
      if (db_wr) db_seen <= 1'b1;
    end
  end

  // R7: a single span in flight
  a_r7_one_span: assert property (@(posedge clk) disable iff (rst)
    span_req |-> !span_open);
  // R7: no slot read while a span is open
  a_r7_no_read_in_span: assert property (@(posedge clk) disable iff (rst)
    ent_req |-> !span_open);
  // R3: no work before any doorbell
  a_r3_needs_doorbell: assert property (@(posedge clk) disable iff (rst)
    ent_req |-> db_seen);
endmodule

// File: tb/sim_ring_fetch_ctrl.sv
`timescale 1ns/1ps
module sim_ring_fetch_ctrl;
  localparam int NCH = 4, RING = 8, DW = 32;
  localparam int CH_W = $clog2(NCH), IDX_W = $clog2(RING);

  logic clk = 1'b0, rst = 1'b1;
  logic db_wr = 0; logic [CH_W-1:0] db_token = '0;
  logic put_we = 0; logic [CH_W-1:0] put_ch = '0; logic [IDX_W-1:0] put_val = '0;
  logic [CH_W-1:0] cur_rd_ch = '0; logic [IDX_W-1:0] cur_rd_get;
  logic ent_req; logic [CH_W+IDX_W-1:0] ent_addr;
  logic ent_rvalid = 0; logic [DW-1:0] ent_base = '0, ent_len = '0;
  logic span_req; logic [CH_W-1:0] span_ch; logic [DW-1:0] span_base, span_len;
  logic span_done = 0;

  ring_fetch_ctrl #(.NCH(NCH), .RING(RING), .DW(DW)) u0 (.*);

  initial forever #2.5 clk = ~clk;

  int checks = 0, bad = 0;
  bit finished = 0;
  logic [63:0] ring_mem [NCH*RING];
  int put_model [NCH];
  logic [71:0] expq [$];
  int seen_ch [$];
  int ent_cnt = 0, span_cnt = 0, span_delay = 1;
  bit b_span_open = 0;
  logic [CH_W+IDX_W-1:0] ent_hold = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Memory and span-consumer model, compared every clock.
  initial forever begin
    @(negedge clk);
    ent_rvalid = 0; span_done = 0;
    if (!rst) begin
      if (ent_cnt > 0) begin
        ent_cnt--;
        if (ent_cnt == 0) begin
          ent_rvalid = 1;
          {ent_base, ent_len} = ring_mem[ent_hold];   // R10 address layout
        end
      end
      if (span_cnt > 0) begin
        span_cnt--;
        if (span_cnt == 0) begin span_done = 1; b_span_open = 0; end
      end
      if (ent_req) begin
        chk(!b_span_open, "R7 slot read while span open", 64'(ent_req), 0);
        chk(int'(ent_addr[IDX_W-1:0]) != put_model[ent_addr[CH_W+IDX_W-1:IDX_W]],
            "R4 slot read at produce index", 64'(ent_addr), 0);
        ent_hold = ent_addr; ent_cnt = 2;
      end
      if (span_req) begin
        int idx;
        idx = -1;
        chk(!b_span_open, "R7 second span outstanding", 64'(span_req), 0);
        chk(span_ch == ent_hold[CH_W+IDX_W-1:IDX_W], "R10 span channel vs slot address",
            64'(span_ch), 64'(ent_hold[CH_W+IDX_W-1:IDX_W]));
        for (int i = 0; i < expq.size(); i++)
          if (expq[i][71:64] == 8'(span_ch)) begin idx = i; break; end
        if (idx < 0) chk(0, "R2 unexpected span", {span_base, span_len}, 0);
        else begin
          chk({span_base, span_len} == expq[idx][63:0], "R2 span base/length",
              {span_base, span_len}, expq[idx][63:0]);
          expq.delete(idx);
        end
        b_span_open = 1; span_cnt = span_delay + 1;
        seen_ch.push_back(int'(span_ch));
      end
    end
  end

  task automatic add_entry(input int ch, input logic [31:0] base, input logic [31:0] len);
    ring_mem[ch*RING + put_model[ch]] = {base, len};
    if (len != 0) expq.push_back({8'(ch), base, len});
    put_model[ch] = (put_model[ch] + 1) % RING;
  endtask

  task automatic put_write(input int ch);
    @(negedge clk); put_we = 1; put_ch = CH_W'(ch); put_val = IDX_W'(put_model[ch]);
    @(negedge clk); put_we = 0;
  endtask

  task automatic ring_db(input int ch);
    @(negedge clk); db_wr = 1; db_token = CH_W'(ch);
    @(negedge clk); db_wr = 0;
  endtask

  task automatic read_get(input int ch, output int v);
    @(negedge clk); cur_rd_ch = CH_W'(ch);
    @(negedge clk); v = int'(cur_rd_get);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (expq.size() == 0 && !b_span_open && ent_cnt == 0) break;
    end
    repeat (12) @(negedge clk);
  endtask

  initial begin
    int v;
    for (int i = 0; i < NCH; i++) put_model[i] = 0;
    for (int i = 0; i < NCH*RING; i++) ring_mem[i] = '0;
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(!span_req && !ent_req, "R1 requests low after reset", {span_req, ent_req}, 0);
    for (int c = 0; c < NCH; c++) begin
      read_get(c, v); chk(v == 0, "R1 consume cursor reset", v, 0);
    end
    // R4 doorbell on an empty ring
    ring_db(3); repeat (30) @(negedge clk);
    chk(seen_ch.size() == 0, "R4 empty ring gives no span", seen_ch.size(), 0);
    read_get(3, v); chk(v == 0, "R4 empty ring cursor", v, 0);
    // R3 produce cursor alone has no effect
    add_entry(1, 32'h1000, 32'd16); add_entry(1, 32'h2000, 32'd8); put_write(1);
    repeat (40) @(negedge clk);
    chk(seen_ch.size() == 0, "R3 no span without doorbell", seen_ch.size(), 0);
    read_get(1, v); chk(v == 0, "R3 cursor untouched without doorbell", v, 0);
    ring_db(1); wait_idle();
    chk(expq.size() == 0, "R3 doorbell drained channel", expq.size(), 0);
    read_get(1, v); chk(v == 2, "R5 consume cursor after two slots", v, 2);
    // R6 zero-length slot skipped
    span_delay = 2;
    add_entry(2, 32'h3000, 32'd5); add_entry(2, 32'h3100, 32'd0); add_entry(2, 32'h3200, 32'd3);
    put_write(2); seen_ch.delete(); ring_db(2); wait_idle();
    chk(seen_ch.size() == 2, "R6 spans for non-empty slots only", seen_ch.size(), 2);
    read_get(2, v); chk(v == 3, "R6 cursor passes empty slot", v, 3);
    // R4 wrap-around on channel 0
    span_delay = 0;
    for (int i = 0; i < 6; i++) add_entry(0, 32'h4000 + 32'(i*64), 32'(i+1));
    put_write(0); ring_db(0); wait_idle();
    for (int i = 0; i < 6; i++) add_entry(0, 32'h5000 + 32'(i*64), 32'(i+9));
    put_write(0); ring_db(0); wait_idle();
    chk(expq.size() == 0, "R4 wrapped slots all fetched", expq.size(), 0);
    read_get(0, v); chk(v == 4, "R4 cursor wraps modulo depth", v, 4);
    // R8 doorbell during an active walk
    span_delay = 6;
    add_entry(1, 32'h6000, 32'd4); add_entry(1, 32'h6100, 32'd4); add_entry(1, 32'h6200, 32'd4);
    put_write(1); ring_db(1);
    repeat (8) @(negedge clk);
    add_entry(1, 32'h6300, 32'd2); add_entry(1, 32'h6400, 32'd7); put_write(1); ring_db(1);
    wait_idle();
    chk(expq.size() == 0, "R8 late slots fetched after reread", expq.size(), 0);
    read_get(1, v); chk(v == 7, "R8 cursor after reread", v, 7);
    // R9 lowest token first, walks not interleaved
    span_delay = 3;
    add_entry(0, 32'h7000, 32'd1); add_entry(0, 32'h7100, 32'd1); put_write(0);
    add_entry(3, 32'h7300, 32'd1); put_write(3);
    add_entry(2, 32'h7200, 32'd1); put_write(2);
    seen_ch.delete();
    ring_db(0); ring_db(3); ring_db(2); wait_idle();
    chk(seen_ch.size() == 4, "R9 span count", seen_ch.size(), 4);
    if (seen_ch.size() == 4) begin
      chk(seen_ch[0] == 0 && seen_ch[1] == 0, "R9 first walk completes", seen_ch[1], 0);
      chk(seen_ch[2] == 2, "R9 lowest pending token next", seen_ch[2], 2);
      chk(seen_ch[3] == 3, "R9 highest token last", seen_ch[3], 3);
    end
    for (int c = 0; c < NCH; c++) begin
      read_get(c, v); chk(v == put_model[c], "R5 final consume cursor", v, put_model[c]);
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule